// File: doc/BRIEF.md
# TDM Timeslot Enable Generator

This block sits between a serial time-division bus and a packet engine. It follows the bus frame by counting bit positions from a frame-start pulse. From that count it produces registered transmit and receive enables that tell the packet engine when it owns the line. A 4-bit timing code picks which slots those are. The code covers a short run of leading bits in channel 0, a whole data channel, or a group of adjacent data channels.

Channel 1 is reserved for a control byte, which is loaded separately and sent most significant bit first whenever insertion is on. The block also captures the byte that arrives on the incoming line in channel 1 of every frame. The serial output has its own output-enable, which is low in every slot the block does not drive, so the pad is high impedance there.

A mode input hands the enables over to two external pins. In that mode the frame pulse only produces a watchdog tick.

Top module: `tdm_slot_gen`

## Requirements
- R1: The bit that follows a sampled frame pulse is bit position 0 of a 256-bit frame (32 channels of 8 bits, channel n covering positions 8n to 8n+7). Enables for position 0 appear on the first rising edge after the pulse is sampled. The counter wraps from 255 to 0 when no pulse arrives.
- R2: With `bit_rate_i` high, every clock cycle is one bit. With it low, each bit lasts two clock cycles, and the cycle pair restarts at each frame pulse.
- R3: In internal mode, `tx_en_o` and `rx_en_o` are both high exactly during the selected positions. The codes are: 0000 = positions 0-1, 0001 = 0-5, 0010 = 0-6, 0011 = 0-7, 0100 = channel 2, 0101 = channel 3, 0110 = channel 4, 0111 = channels 2 and 3, 1000 = channels 2, 3 and 4.
- R4: Codes 1001 to 1111 enable nothing, and no code ever enables a data position inside channel 1 (positions 8-15).
- R5: With `int_timing_i` and `cch_en_i` high, `ser_oe_o` is high through channel 1. `ser_d_o` carries the value of `cch_tx_byte_i` taken as channel 1 begins, bit 7 at position 8 down to bit 0 at position 15.
- R6: In internal mode, `ser_oe_o` is high only in enabled data positions and in channel 1 when insertion is on. In enabled data positions `ser_d_o` follows `tx_bit_i`.
- R7: With `int_timing_i` low, `tx_en_o`, `rx_en_o` and `ser_oe_o` take the values of `ext_tx_en_i`, `ext_rx_en_i` and `ext_tx_en_i` one cycle later, and nothing is inserted in channel 1.
- R8: After the first frame pulse, `ser_i` is sampled on the last clock cycle of each bit of channel 1, bit 7 first. After position 15 the byte appears on `cch_rx_byte_o` together with a one-cycle `cch_rx_valid_o` pulse. A frame pulse that arrives inside channel 1 abandons that capture.
- R9: Between reset and the first frame pulse, internal mode drives no enable and `ser_oe_o` stays low.
- R10: `wd_tick_o` is high for one cycle after every cycle in which `frame_pulse_i` is sampled high, in either mode.
- R11: While `rst_n` is low at a clock edge, every output register clears to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, at the bit rate or twice the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_pulse_i | input | 1 | Frame start, one clock wide |
| bit_rate_i | input | 1 | 1: clock equals bit rate; 0: clock is twice the bit rate |
| int_timing_i | input | 1 | 1: enables from the slot counter; 0: enables from pins |
| tc_code_i | input | 4 | Timing code selecting the enabled positions |
| cch_en_i | input | 1 | Insert the control byte in channel 1 |
| cch_tx_byte_i | input | 8 | Control byte to insert |
| ext_tx_en_i | input | 1 | External transmit enable (external mode) |
| ext_rx_en_i | input | 1 | External receive enable (external mode) |
| tx_bit_i | input | 1 | Serial data from the packet engine |
| ser_i | input | 1 | Incoming serial line |
| tx_en_o | output | 1 | Transmit enable |
| rx_en_o | output | 1 | Receive enable |
| ser_d_o | output | 1 | Serial output data |
| ser_oe_o | output | 1 | Serial output drive enable; low means high impedance |
| cch_rx_byte_o | output | 8 | Last control byte received |
| cch_rx_valid_o | output | 1 | One-cycle pulse when `cch_rx_byte_o` updates |
| wd_tick_o | output | 1 | Watchdog tick derived from the frame pulse |

## Verification
The hardest case to reach is a frame pulse that lands inside channel 1 while a received byte is half assembled and the control byte is being shifted out. In that case the capture must be dropped and the insertion cut short. The same applies at half rate, where the pulse can fall on either cycle of a bit. The stimulus ends some frames early, at chosen positions, so that pulses arrive mid-channel and mid-bit. It also switches mode and clock rate between frames. A behavioural model in the bench follows every cycle of this.

// File: rtl/tdm_pkg.sv
// Shared types for the TDM slot enable generator.
// Assumes an 8-bit channel; the code values are the ones listed in the brief.
package tdm_pkg;

    typedef enum logic [3:0] {
        TC_LEAD2  = 4'd0,
        TC_LEAD6  = 4'd1,
        TC_LEAD7  = 4'd2,
        TC_LEAD8  = 4'd3,
        TC_CH2    = 4'd4,
        TC_CH3    = 4'd5,
        TC_CH4    = 4'd6,
        TC_CH23   = 4'd7,
        TC_CH234  = 4'd8
    } tc_code_e;

    // Number of leading channel-0 bits for a partial code, 0 for other codes.
    function automatic int unsigned lead_bits(input logic [3:0] code);
        case (code)
            TC_LEAD2: lead_bits = 2;
            TC_LEAD6: lead_bits = 6;
            TC_LEAD7: lead_bits = 7;
            TC_LEAD8: lead_bits = 8;
            default:  lead_bits = 0;
        endcase
    endfunction

endpackage

// File: rtl/tdm_bit_timer.sv
// Bit position counter.
// Resets to position 0 on each frame pulse and wraps at the end of the frame.
// When bit_rate_i is low, each bit takes two clocks.
// Exports next-state values so the registers downstream change on the same edge.
module tdm_bit_timer #(
    parameter int POS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_pulse_i,
    input  logic             bit_rate_i,
    output logic [POS_W-1:0] pos_q,
    output logic [POS_W-1:0] pos_nxt,
    output logic             bit_end,
    output logic             step,
    output logic             synced_q,
    output logic             synced_nxt
);
    logic half_q;

    // Next bit position and alignment state.
    always_comb begin
        bit_end    = bit_rate_i | half_q;
        step       = frame_pulse_i | bit_end;
        synced_nxt = synced_q | frame_pulse_i;
        if (frame_pulse_i)
            pos_nxt = '0;
        else if (bit_end)
            pos_nxt = pos_q + 1'b1;
        else
            pos_nxt = pos_q;
    end

    // Position, half-bit phase and first-pulse flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q    <= '0;
            half_q   <= 1'b0;
            synced_q <= 1'b0;
        end else begin
            pos_q    <= pos_nxt;
            half_q   <= !step;
            synced_q <= synced_nxt;
        end
    end

    assert_resync_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse_i |=> (pos_q == '0) && !half_q);

    assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == '1 && bit_end && !frame_pulse_i) |=> pos_q == '0);

    assert_half_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_rate_i && !frame_pulse_i && !half_q) |=> $stable(pos_q) && half_q);

endmodule

// File: rtl/tdm_slot_decode.sv
// Maps a bit position and a timing code to a data-slot hit and a control-slot hit.
// Purely combinational. Assumes NUM_CH >= 5 and CH_BITS = 8.
module tdm_slot_decode
    import tdm_pkg::*;
#(
    parameter int NUM_CH   = 32,
    parameter int CH_BITS  = 8,
    parameter int CCH_SLOT = 1,
    parameter int POS_W    = 8
) (
    input  logic [3:0]       code_i,
    input  logic [POS_W-1:0] pos_i,
    output logic             data_hit_o,
    output logic             cch_hit_o
);
    localparam int CH_W   = $clog2(CH_BITS);
    localparam int CHAN_W = POS_W - CH_W;

    logic [NUM_CH-1:0] ch_sel;
    logic [CH_W-1:0]   offset;

    // One select line per channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chsel
        assign ch_sel[g] = (pos_i[POS_W-1:CH_W] == CHAN_W'(g));
    end

    assign offset    = pos_i[CH_W-1:0];
    assign cch_hit_o = ch_sel[CCH_SLOT];

    // Enabled data positions for each code.
    always_comb begin
        case (code_i)
            TC_LEAD2, TC_LEAD6, TC_LEAD7, TC_LEAD8:
                data_hit_o = ch_sel[0] && (32'(offset) < lead_bits(code_i));
            TC_CH2:   data_hit_o = ch_sel[2];
            TC_CH3:   data_hit_o = ch_sel[3];
            TC_CH4:   data_hit_o = ch_sel[4];
            TC_CH23:  data_hit_o = ch_sel[2] | ch_sel[3];
            TC_CH234: data_hit_o = ch_sel[2] | ch_sel[3] | ch_sel[4];
            default:  data_hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/tdm_cch_tx.sv
// Control-byte serialiser.
// Loads the byte as the control channel begins and shifts it out MSB first, one bit per bit step.
// The caller gates the output with its own drive flag.
module tdm_cch_tx #(
    parameter int CH_BITS  = 8,
    parameter int CCH_SLOT = 1,
    parameter int POS_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_i,
    input  logic [POS_W-1:0]   pos_nxt_i,
    input  logic [CH_BITS-1:0] byte_i,
    output logic               bit_o
);
    localparam logic [POS_W-1:0] FIRST_POS = POS_W'(CCH_SLOT * CH_BITS);

    logic [CH_BITS-1:0] shreg;

    // Load at the start of the control channel, otherwise shift on each bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else if (step_i) begin
            if (pos_nxt_i == FIRST_POS)
                shreg <= byte_i;
            else
                shreg <= {shreg[CH_BITS-2:0], 1'b0};
        end
    end

    assign bit_o = shreg[CH_BITS-1];

    assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && pos_nxt_i == FIRST_POS) |=> bit_o == $past(byte_i[CH_BITS-1]));

endmodule

// File: rtl/tdm_cch_rx.sv
// Control-byte receiver.
// Samples the line on the last cycle of each control-channel bit, MSB first.
// Publishes the byte with a one-cycle valid after the last bit. Captures only after the first frame pulse.
module tdm_cch_rx #(
    parameter int CH_BITS  = 8,
    parameter int CCH_SLOT = 1,
    parameter int POS_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               synced_i,
    input  logic               bit_done_i,
    input  logic [POS_W-1:0]   pos_i,
    input  logic               ser_i,
    output logic [CH_BITS-1:0] byte_o,
    output logic               valid_o
);
    localparam int CH_W   = $clog2(CH_BITS);
    localparam int CHAN_W = POS_W - CH_W;

    logic [CH_BITS-1:0] acc;
    logic               in_slot, last_bit, take;

    assign in_slot  = (pos_i[POS_W-1:CH_W] == CHAN_W'(CCH_SLOT));
    assign last_bit = in_slot && (pos_i[CH_W-1:0] == '1);
    assign take     = synced_i && bit_done_i && in_slot;

    // Assemble the byte and publish it after the final bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            byte_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= take && last_bit;
            if (take) begin
                acc <= {acc[CH_BITS-2:0], ser_i};
                if (last_bit)
                    byte_o <= {acc[CH_BITS-2:0], ser_i};
            end
        end
    end

    assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_valid_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(synced_i) && ($past(pos_i[CH_W-1:0]) == '1));

endmodule

// File: rtl/tdm_slot_gen.sv
// TDM timeslot enable generator, top level.
// Registers the transmit/receive enables, the serial output enable and the control-byte drive flag.
// All of them are computed from the next bit position, so they change on the edge that starts a bit.
// Assumes the frame pulse is one clock wide.
module tdm_slot_gen #(
    parameter int NUM_CH   = 32,
    parameter int CH_BITS  = 8,
    parameter int CCH_SLOT = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_pulse_i,
    input  logic               bit_rate_i,
    input  logic               int_timing_i,
    input  logic [3:0]         tc_code_i,
    input  logic               cch_en_i,
    input  logic [CH_BITS-1:0] cch_tx_byte_i,
    input  logic               ext_tx_en_i,
    input  logic               ext_rx_en_i,
    input  logic               tx_bit_i,
    input  logic               ser_i,
    output logic               tx_en_o,
    output logic               rx_en_o,
    output logic               ser_d_o,
    output logic               ser_oe_o,
    output logic [CH_BITS-1:0] cch_rx_byte_o,
    output logic               cch_rx_valid_o,
    output logic               wd_tick_o
);
    localparam int FRAME_BITS = NUM_CH * CH_BITS;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int CH_W       = $clog2(CH_BITS);
    localparam int CHAN_W     = POS_W - CH_W;

    logic [POS_W-1:0] pos_q, pos_nxt;
    logic             bit_end, step, synced_q, synced_nxt;
    logic             data_hit, cch_hit, cch_bit, drive_q;

    tdm_bit_timer #(.POS_W(POS_W)) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_pulse_i (frame_pulse_i),
        .bit_rate_i    (bit_rate_i),
        .pos_q         (pos_q),
        .pos_nxt       (pos_nxt),
        .bit_end       (bit_end),
        .step          (step),
        .synced_q      (synced_q),
        .synced_nxt    (synced_nxt)
    );

    tdm_slot_decode #(
        .NUM_CH(NUM_CH), .CH_BITS(CH_BITS), .CCH_SLOT(CCH_SLOT), .POS_W(POS_W)
    ) u_decode (
        .code_i     (tc_code_i),
        .pos_i      (pos_nxt),
        .data_hit_o (data_hit),
        .cch_hit_o  (cch_hit)
    );

    tdm_cch_tx #(.CH_BITS(CH_BITS), .CCH_SLOT(CCH_SLOT), .POS_W(POS_W)) u_cch_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .pos_nxt_i (pos_nxt),
        .byte_i    (cch_tx_byte_i),
        .bit_o     (cch_bit)
    );

    tdm_cch_rx #(.CH_BITS(CH_BITS), .CCH_SLOT(CCH_SLOT), .POS_W(POS_W)) u_cch_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .synced_i   (synced_q),
        .bit_done_i (bit_end && !frame_pulse_i),
        .pos_i      (pos_q),
        .ser_i      (ser_i),
        .byte_o     (cch_rx_byte_o),
        .valid_o    (cch_rx_valid_o)
    );

    // Output enables: counter-driven in internal mode, pin-driven otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_o   <= 1'b0;
            rx_en_o   <= 1'b0;
            ser_oe_o  <= 1'b0;
            drive_q   <= 1'b0;
            wd_tick_o <= 1'b0;
        end else begin
            wd_tick_o <= frame_pulse_i;
            if (int_timing_i) begin
                tx_en_o  <= synced_nxt && data_hit;
                rx_en_o  <= synced_nxt && data_hit;
                drive_q  <= synced_nxt && cch_en_i && cch_hit;
                ser_oe_o <= synced_nxt && (data_hit || (cch_en_i && cch_hit));
            end else begin
                tx_en_o  <= ext_tx_en_i;
                rx_en_o  <= ext_rx_en_i;
                drive_q  <= 1'b0;
                ser_oe_o <= ext_tx_en_i;
            end
        end
    end

    // Serial data: control byte while inserting, packet data otherwise.
    assign ser_d_o = drive_q ? cch_bit : tx_bit_i;

    assert_ch1_no_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(int_timing_i) && (tx_en_o || rx_en_o)) |-> pos_q[POS_W-1:CH_W] != CHAN_W'(CCH_SLOT));

    assert_tx_rx_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(int_timing_i) |-> tx_en_o == rx_en_o);

    assert_oe_scope_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_oe_o && !tx_en_o) |-> $past(int_timing_i) && $past(cch_en_i)
                                   && pos_q[POS_W-1:CH_W] == CHAN_W'(CCH_SLOT));

    assert_unsync_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(int_timing_i) && !synced_q) |-> !ser_oe_o && !tx_en_o);

endmodule

// File: tb/tb_tdm_slot_gen.sv
`timescale 1ns/1ps
module tb_tdm_slot_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fp = 1'b0, rate = 1'b1, intm = 1'b1, cch_en = 1'b0;
    logic [3:0] code = 4'd0;
    logic [7:0] tx_byte = 8'h00;
    logic       ext_tx = 1'b0, ext_rx = 1'b0, tx_bit = 1'b0, ser_in = 1'b0;
    logic       tx_en, rx_en, ser_d, ser_oe, rx_val, wd;
    logic [7:0] rx_byte;

    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    tdm_slot_gen dut (
        .clk(clk), .rst_n(rst_n), .frame_pulse_i(fp), .bit_rate_i(rate),
        .int_timing_i(intm), .tc_code_i(code), .cch_en_i(cch_en),
        .cch_tx_byte_i(tx_byte), .ext_tx_en_i(ext_tx), .ext_rx_en_i(ext_rx),
        .tx_bit_i(tx_bit), .ser_i(ser_in), .tx_en_o(tx_en), .rx_en_o(rx_en),
        .ser_d_o(ser_d), .ser_oe_o(ser_oe), .cch_rx_byte_o(rx_byte),
        .cch_rx_valid_o(rx_val), .wd_tick_o(wd)
    );

    // Reference model state
    int   m_pos = 0;
    bit   m_half = 0, m_sync = 0, m_rst = 1, m_int = 1, m_rate = 1, started = 0;
    int   m_code = 0;
    logic [7:0] m_acc = 0, m_lat = 0, e_rxb = 0;
    bit   e_tx = 0, e_rx = 0, e_oe = 0, e_drv = 0, e_val = 0, e_wd = 0;

    function automatic bit exp_hit(int c, int p);
        case (c)
            0: return p <= 1;
            1: return p <= 5;
            2: return p <= 6;
            3: return p <= 7;
            4: return p >= 16 && p <= 23;
            5: return p >= 24 && p <= 31;
            6: return p >= 32 && p <= 39;
            7: return p >= 16 && p <= 31;
            8: return p >= 16 && p <= 39;
            default: return 0;
        endcase
    endfunction

    // Cycle model, updated on each rising edge
    always @(posedge clk) begin
        bit adv;
        started = 1;
        if (!rst_n) begin
            m_pos = 0; m_half = 0; m_sync = 0; m_acc = 0; m_lat = 0; m_rst = 1;
            e_tx = 0; e_rx = 0; e_oe = 0; e_drv = 0; e_rxb = 0; e_val = 0; e_wd = 0;
        end else begin
            m_rst = 0;
            m_int = intm; m_rate = rate; m_code = int'(code);
            adv = rate || m_half;
            e_val = 0;
            if (m_sync && adv && !fp && m_pos >= 8 && m_pos <= 15) begin
                m_acc = {m_acc[6:0], ser_in};
                if (m_pos == 15) begin e_rxb = m_acc; e_val = 1; end
            end
            if (fp) begin m_pos = 0; m_half = 0; m_sync = 1; end
            else if (adv) begin m_pos = (m_pos + 1) % 256; m_half = 0; end
            else m_half = 1;
            if ((fp || adv) && m_pos == 8) m_lat = tx_byte;
            e_wd = fp;
            if (intm) begin
                e_tx  = m_sync && exp_hit(int'(code), m_pos);
                e_rx  = e_tx;
                e_drv = m_sync && cch_en && m_pos >= 8 && m_pos <= 15;
                e_oe  = e_tx || e_drv;
            end else begin
                e_tx = ext_tx; e_rx = ext_rx; e_drv = 0; e_oe = ext_tx;
            end
        end
    end

    task automatic chk(string req, string name, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (pos %0d)", req, name, act, exp, m_pos);
        end
    endtask

    function automatic string en_tag();
        if (m_rst) return "R11";
        if (!m_int) return "R7";
        if (!m_sync) return "R9";
        if (m_code > 8 || (m_pos >= 8 && m_pos <= 15)) return "R4";
        if (!m_rate) return "R2";
        if (m_pos < 8) return "R1";
        return "R3";
    endfunction

    // Compare away from the rising edge
    always @(negedge clk) begin
        if (started) begin
            chk(en_tag(), "tx_en", {7'd0, tx_en}, {7'd0, e_tx});
            chk(en_tag(), "rx_en", {7'd0, rx_en}, {7'd0, e_rx});
            chk(m_rst ? "R11" : (m_int ? "R6" : "R7"), "ser_oe", {7'd0, ser_oe}, {7'd0, e_oe});
            if (e_oe)
                chk(e_drv ? "R5" : "R6", "ser_d", {7'd0, ser_d},
                    {7'd0, e_drv ? m_lat[15 - m_pos] : tx_bit});
            chk(m_rst ? "R11" : "R8", "rx_valid", {7'd0, rx_val}, {7'd0, e_val});
            chk(m_rst ? "R11" : "R8", "rx_byte", rx_byte, e_rxb);
            chk(m_rst ? "R11" : "R10", "wd_tick", {7'd0, wd}, {7'd0, e_wd});
        end
    end

    // One frame of len cycles, frame pulse in the first cycle when with_fp is set
    task automatic run(int len, bit with_fp);
        for (int c = 0; c < len; c++) begin
            @(negedge clk); #1;
            fp     = with_fp && (c == 0);
            ser_in = 1'($urandom);
            tx_bit = 1'($urandom);
            ext_tx = 1'($urandom);
            ext_rx = 1'($urandom);
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        code = 4'd3; cch_en = 1'b1; tx_byte = 8'hA5;
        run(300, 1'b0);                          // R9: no frame pulse yet
        for (int k = 0; k < 16; k++) begin       // R3/R4: every code at full rate
            code = 4'(k); cch_en = k[0]; tx_byte = 8'(k * 37 + 11);
            run(256, 1'b1);
        end
        code = 4'd8; cch_en = 1'b1; tx_byte = 8'h3C;
        run(12, 1'b1);                           // pulse lands inside channel 1
        run(100, 1'b1);                          // short frame
        run(300, 1'b1);                          // long frame, wrap past 255 (R1)
        rate = 1'b0;                             // R2: half rate
        for (int k = 0; k < 4; k++) begin
            code = (k == 3) ? 4'd7 : 4'(k * 4); tx_byte = 8'(8'h81 ^ k);
            run(512, 1'b1);
        end
        run(21, 1'b1);                           // pulse mid-bit inside channel 1
        run(27, 1'b1);
        run(512, 1'b1);
        intm = 1'b0;                             // R7: external enables
        run(256, 1'b1); run(256, 1'b1);
        rate = 1'b1; intm = 1'b1; code = 4'd0; cch_en = 1'b1;
        run(256, 1'b1);
        @(negedge clk); #1 rst_n = 1'b0;         // R11: reset mid-frame
        run(3, 1'b0);
        @(negedge clk); #1 rst_n = 1'b1;
        run(256, 1'b1); run(256, 1'b1);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule